// File: doc/BRIEF.md
# Extended external interrupt controller

This block gathers 40 level-sensitive interrupt request lines into 40 interrupt outputs. Software controls it through a small memory-mapped register port. The lines are split into two banks. Bank 0 holds lines 0 to 31 and bank 1 holds lines 32 to 39. Each bank has six registers: an interrupt mask, an event mask (stored only), a rising-edge select, a falling-edge select, a software trigger and a pending register that is cleared by writing 1.

A fixed constant marks some lines as direct lines. An unmasked direct line copies its input level to its output and never latches anything. Every other line is configurable. On a configurable line, a selected edge, or a software trigger, sets a pending bit and gives a one-cycle pulse on the output. The block samples the input levels on every clock and keeps the previous level of each line. It acts only where that level has changed.

Register accesses take one cycle and use a valid strobe, a write enable, a byte address and 32-bit data. Read data is registered and appears one cycle after the request.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset, the mask register of each bank equals that bank's direct-line constant (bank 0 0xFF820000, bank 1 0x00000087). Every other register, the read data and all outputs are zero.
- R2: A write to a mask or event-mask register stores all of that bank's valid bits (32 in bank 0, 8 in bank 1). The readback shows those bits, and bank 1 reads zero above bit 7.
- R3: A write to a rising-select, falling-select, software-trigger or pending register keeps only the configurable bits. Configurable bits are the valid bits not in the direct-line constant. Direct-line positions always read zero there.
- R4: On an unmasked direct line, a change of input level appears on its output one clock later. The output keeps that level, and no pending bit is set.
- R5: On an unmasked configurable line, the following two cases each set the line's pending bit and drive its output high for exactly one cycle, one clock after the change. A change to 1 with its rising-select bit set. A change to 0 with its falling-select bit set. A change in a direction that is not selected does nothing.
- R6: A change on a masked line sets no pending bit and leaves the output unchanged. The stored previous level still updates, so unmasking a line later does not fire it.
- R7: On a software-trigger write, a bit is acted on only if it goes from 0 to 1, is unmasked and is not pending. Such a bit sets its pending bit and pulses its output once, one clock after the write. The written value is stored in either case, so writing the same value again does nothing.
- R8: Writing 1 to a set pending bit clears it and also clears the matching software-trigger bit. Writing 0 to a pending bit has no effect. Writing 1 to a pending bit that is clear leaves the software-trigger bit as it is.
- R9: A pending-clear write and a detected edge on the same bit in the same cycle leave the bit clear. The edge pulse is still produced.
- R10: Register map: bank b starts at byte 0x20*b. The offsets within a bank are mask 0x00, event mask 0x04, rising 0x08, falling 0x0C, software trigger 0x10 and pending 0x14. Any other offset in the 0x400 window, and any address not a multiple of 4, reads as zero and ignores writes.
- R11: Read data is valid one cycle after the read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Byte address within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| line_in | input | 40 | Interrupt request levels |
| irq_out | output | 40 | Interrupt outputs (level for direct lines, pulse for configurable lines) |

## Verification
Every result in this block is due exactly one clock edge after its cause. Three results appear after that edge: read data for a request, the level or pulse on an output after an input change, and the pulse and pending bit after a software-trigger write. The bench changes inputs and requests at a falling clock edge and samples at the next falling edge, so exactly one rising edge lies between stimulus and check. Pulse width is checked by sampling again one further falling edge later and expecting zero. Pending state is read back through the register port after each event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register select within one bank; the value is the word offset (byte offset / 4)
    typedef enum logic [2:0] {
        SEL_IMR  = 3'd0,
        SEL_EMR  = 3'd1,
        SEL_RISE = 3'd2,
        SEL_FALL = 3'd3,
        SEL_SWT  = 3'd4,
        SEL_PND  = 3'd5
    } irqc_sel_e;

    localparam int LINES_PER_BANK   = 32;
    localparam int BANK_STRIDE_LOG2 = 5;   // 0x20 bytes per bank
    localparam int REGS_PER_BANK    = 6;

endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
    import irqc_pkg::*;
#(
    parameter  int ADDR_W = 10,
    parameter  int NBANKS = 2,
    localparam int BIDX_W = ADDR_W - BANK_STRIDE_LOG2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BIDX_W-1:0] bank,
    output irqc_sel_e         sel
);

    logic [2:0] word;

    always_comb begin
        word = addr[BANK_STRIDE_LOG2-1:2];
        bank = addr[ADDR_W-1:BANK_STRIDE_LOG2];
        sel  = irqc_sel_e'(word);
        hit  = (addr[1:0] == 2'b00)
            && (int'(word) < REGS_PER_BANK)
            && (int'(bank) < NBANKS);
    end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int         W     = 32,
    parameter logic [W-1:0] DMASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  irqc_sel_e    sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] line_in,
    output logic [W-1:0] rd_val,
    output logic [W-1:0] irq_out
);

    localparam logic [W-1:0] CFG = ~DMASK;

    typedef struct packed {
        logic [W-1:0] imr;
        logic [W-1:0] emr;
        logic [W-1:0] rise;
        logic [W-1:0] fall;
        logic [W-1:0] swt;
        logic [W-1:0] pnd;
        logic [W-1:0] lvl;   // previous input level
        logic [W-1:0] dir;   // direct-line output level
        logic [W-1:0] pls;   // configurable-line pulse
    } bank_st_t;

    localparam bank_st_t RST_ST = '{imr: DMASK, default: '0};

    bank_st_t     st_d, st_q;
    logic [W-1:0] chg, edge_hit, dir_upd, sw_hit, clr;

    always_comb begin
        st_d     = st_q;
        chg      = line_in ^ st_q.lvl;
        edge_hit = st_q.imr & CFG &
                   ((chg & line_in & st_q.rise) | (chg & ~line_in & st_q.fall));
        dir_upd  = chg & st_q.imr & DMASK;
        sw_hit   = '0;
        clr      = '0;

        st_d.lvl = line_in;
        st_d.dir = (st_q.dir & ~dir_upd) | (line_in & dir_upd);

        if (wr_en) begin
            case (sel)
                SEL_IMR:  st_d.imr  = wdata;
                SEL_EMR:  st_d.emr  = wdata;
                SEL_RISE: st_d.rise = wdata & CFG;
                SEL_FALL: st_d.fall = wdata & CFG;
                SEL_SWT: begin
                    sw_hit   = wdata & CFG & ~st_q.swt & st_q.imr & ~st_q.pnd;
                    st_d.swt = wdata & CFG;
                end
                SEL_PND: begin
                    clr      = wdata & CFG;
                    st_d.swt = st_q.swt & ~(st_q.pnd & clr);
                end
                default: ;
            endcase
        end

        // a clear in the same cycle wins over a new edge
        st_d.pnd = (st_q.pnd | edge_hit | sw_hit) & ~clr;
        st_d.pls = edge_hit | sw_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_IMR:  rd_val = st_q.imr;
            SEL_EMR:  rd_val = st_q.emr;
            SEL_RISE: rd_val = st_q.rise;
            SEL_FALL: rd_val = st_q.fall;
            SEL_SWT:  rd_val = st_q.swt;
            SEL_PND:  rd_val = st_q.pnd;
            default:  rd_val = '0;
        endcase
    end

    assign irq_out = (st_q.dir & DMASK) | (st_q.pls & CFG);

endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
    import irqc_pkg::*;
#(
    parameter  int          NUM_LINES   = 40,
    parameter  int          ADDR_W      = 10,
    parameter  logic [63:0] DIRECT_MASK = 64'h0000_0087_FF82_0000,
    localparam int          NBANKS      = (NUM_LINES + LINES_PER_BANK - 1) / LINES_PER_BANK,
    localparam int          BIDX_W      = ADDR_W - BANK_STRIDE_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] irq_out
);

    typedef struct packed {
        logic [31:0] rdata;
    } top_st_t;

    top_st_t               st_d, st_q;
    logic                  hit;
    logic [BIDX_W-1:0]     bank_idx;
    irqc_sel_e             sel;
    logic [32*NBANKS-1:0]  rd_flat;
    logic [31:0]           rd_sel;
    logic                  wr_hit;

    irqc_regdec #(.ADDR_W(ADDR_W), .NBANKS(NBANKS)) u_dec (
        .addr (reg_addr),
        .hit  (hit),
        .bank (bank_idx),
        .sel  (sel)
    );

    assign wr_hit = reg_valid && reg_write && hit;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        localparam int LO = LINES_PER_BANK * b;
        localparam int BW = (NUM_LINES - LO > LINES_PER_BANK) ? LINES_PER_BANK
                                                              : NUM_LINES - LO;
        logic [BW-1:0] rd_raw;

        irqc_bank #(.W(BW), .DMASK(DIRECT_MASK[LO +: BW])) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit && (bank_idx == BIDX_W'(b))),
            .sel     (sel),
            .wdata   (reg_wdata[BW-1:0]),
            .line_in (line_in[LO +: BW]),
            .rd_val  (rd_raw),
            .irq_out (irq_out[LO +: BW])
        );

        assign rd_flat[32*b +: 32] = 32'(rd_raw);
    end

    always_comb begin
        rd_sel = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (bank_idx == BIDX_W'(b)) rd_sel = rd_flat[32*b +: 32];
        end
        st_d = st_q;
        if (reg_valid && !reg_write) st_d.rdata = hit ? rd_sel : 32'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter  int          NUM_LINES   = 40,
    parameter  int          ADDR_W      = 10,
    parameter  logic [63:0] DIRECT_MASK = 64'h0000_0087_FF82_0000,
    localparam int          NBANKS      = (NUM_LINES + 31) / 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_valid,
    input logic                 reg_write,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [31:0]          reg_wdata,
    input logic [31:0]          reg_rdata,
    input logic [NUM_LINES-1:0] line_in,
    input logic [NUM_LINES-1:0] irq_out
);

    logic [1:0] age;
    logic       warm;
    logic       rd_req, rd_bad;

    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assign warm   = (age >= 2'd2);
    assign rd_req = reg_valid && !reg_write;
    assign rd_bad = (reg_addr[1:0] != 2'b00) || (reg_addr[4:2] > 3'd5)
                 || (int'(reg_addr[ADDR_W-1:5]) >= NBANKS);

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(!rd_req) |-> $stable(reg_rdata)); // R11

    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(rd_req && rd_bad) |-> reg_rdata == 32'h0); // R10

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (DIRECT_MASK[i]) begin : g_dir
            AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                warm && (irq_out[i] != $past(irq_out[i])) |->
                    (irq_out[i] == $past(line_in[i]))
                    && ($past(line_in[i]) != $past(line_in[i], 2))); // R4
        end else begin : g_cfg
            localparam int SWT_ADDR = 32 * (i / 32) + 16;
            AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                warm && irq_out[i] |->
                    ($past(line_in[i]) != $past(line_in[i], 2))
                    || $past(reg_valid && reg_write
                             && reg_addr == ADDR_W'(SWT_ADDR))); // R5
        end
    end

    logic unused_ok;
    assign unused_ok = ^reg_wdata;

endmodule

bind irq_line_ctrl irqc_checker #(
    .NUM_LINES   (NUM_LINES),
    .ADDR_W      (ADDR_W),
    .DIRECT_MASK (DIRECT_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .line_in   (line_in),
    .irq_out   (irq_out)
);

// File: tb/irq_line_ctrl_test.sv
module irq_line_ctrl_test;

    localparam int          NL = 40;
    localparam logic [63:0] DM = 64'h0000_0087_FF82_0000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_valid, reg_write;
    logic [9:0]    reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [NL-1:0] line_in;
    logic [NL-1:0] irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_line_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_in(line_in), .irq_out(irq_out)
    );

    function automatic logic [31:0] dmw(int b);
        return DM[32*b +: 32];
    endfunction
    function automatic logic [31:0] valw(int b);
        return (b == 0) ? 32'hFFFF_FFFF : 32'h0000_00FF;
    endfunction
    function automatic logic [31:0] cfgw(int b);
        return valw(b) & ~dmw(b);
    endfunction
    function automatic int ra(int b, int r);
        return 32 * b + 4 * r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 10'(a); reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rdchk(string req, int a, logic [31:0] exp);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 10'(a);
        @(negedge clk);
        reg_valid = 1'b0;
        chk(req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_valid = 1'b0; reg_write = 1'b0;
        reg_addr = '0; reg_wdata = '0; line_in = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 irq_out", 64'(irq_out), 64'h0);
        chk("R1 rdata", 64'(reg_rdata), 64'h0);
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 6; r++)
                rdchk("R1 reg reset", ra(b, r), (r == 0) ? dmw(b) : 32'h0);

        // R11 read latency and hold
        rdchk("R11 read", ra(0, 0), dmw(0));
        step(); step();
        chk("R11 hold", 64'(reg_rdata), 64'(dmw(0)));

        // R2 mask / event mask keep valid bits
        for (int b = 0; b < 2; b++) begin
            wr(ra(b, 0), 32'hFFFF_FFFF);
            rdchk("R2 mask", ra(b, 0), valw(b));
            wr(ra(b, 1), 32'hFFFF_FFFF);
            rdchk("R2 event mask", ra(b, 1), valw(b));
            wr(ra(b, 1), 32'h0);
            rdchk("R2 event mask clear", ra(b, 1), 32'h0);
        end

        // R3 trigger-select registers keep configurable bits
        for (int b = 0; b < 2; b++) begin
            wr(ra(b, 2), 32'hFFFF_FFFF);
            rdchk("R3 rising", ra(b, 2), cfgw(b));
            wr(ra(b, 3), 32'hFFFF_FFFF);
            rdchk("R3 falling", ra(b, 3), cfgw(b));
            wr(ra(b, 2), 32'h0);
            wr(ra(b, 3), 32'h0);
        end

        // R4 direct lines follow input level
        for (int i = 0; i < NL; i++) begin
            if (DM[i]) begin
                step(); line_in[i] = 1'b1;
                step();
                chk("R4 direct high", 64'(irq_out), 64'(1) << i);
                rdchk("R4 no pending", ra(i / 32, 5), 32'h0);
                chk("R4 level held", 64'(irq_out), 64'(1) << i);
                line_in[i] = 1'b0;
                step();
                chk("R4 direct low", 64'(irq_out), 64'h0);
            end
        end

        // R5 edge detection for every configurable line and select combination
        for (int i = 0; i < NL; i++) begin
            if (!DM[i]) begin
                for (int c = 0; c < 4; c++) begin
                    automatic int          b   = i / 32;
                    automatic logic [31:0] bit_w = 32'(1) << (i % 32);
                    automatic bit          rs  = c[0];
                    automatic bit          fs  = c[1];
                    wr(ra(b, 2), rs ? bit_w : 32'h0);
                    wr(ra(b, 3), fs ? bit_w : 32'h0);
                    step(); line_in[i] = 1'b1;
                    step();
                    chk("R5 rise pulse", 64'(irq_out), rs ? (64'(1) << i) : 64'h0);
                    step();
                    chk("R5 one cycle", 64'(irq_out), 64'h0);
                    rdchk("R5 rise pending", ra(b, 5), rs ? bit_w : 32'h0);
                    wr(ra(b, 5), bit_w);
                    rdchk("R8 pending cleared", ra(b, 5), 32'h0);
                    line_in[i] = 1'b0;
                    step();
                    chk("R5 fall pulse", 64'(irq_out), fs ? (64'(1) << i) : 64'h0);
                    step();
                    chk("R5 fall one cycle", 64'(irq_out), 64'h0);
                    rdchk("R5 fall pending", ra(b, 5), fs ? bit_w : 32'h0);
                    wr(ra(b, 5), bit_w);
                end
            end
        end
        wr(ra(0, 2), cfgw(0)); wr(ra(0, 3), cfgw(0));
        wr(ra(1, 2), cfgw(1)); wr(ra(1, 3), cfgw(1));

        // R6 masked lines (configurable 5, direct 17)
        wr(ra(0, 0), 32'hFFFF_FFFF & ~32'h0002_0020);
        step(); line_in[5] = 1'b1; line_in[17] = 1'b1;
        step();
        chk("R6 masked no output", 64'(irq_out), 64'h0);
        rdchk("R6 masked no pending", ra(0, 5), 32'h0);
        wr(ra(0, 0), 32'hFFFF_FFFF);
        chk("R6 unmask no fire", 64'(irq_out), 64'h0);
        rdchk("R6 unmask no pending", ra(0, 5), 32'h0);
        line_in[5] = 1'b0; line_in[17] = 1'b0;
        step();
        chk("R6 level tracked", 64'(irq_out), 64'h20);
        rdchk("R6 pending after fall", ra(0, 5), 32'h20);
        wr(ra(0, 5), 32'h20);

        // R7 software trigger
        wr(ra(0, 4), 32'h8);
        chk("R7 sw pulse", 64'(irq_out), 64'h8);
        step();
        chk("R7 sw one cycle", 64'(irq_out), 64'h0);
        rdchk("R7 sw pending", ra(0, 5), 32'h8);
        rdchk("R7 sw stored", ra(0, 4), 32'h8);
        wr(ra(0, 4), 32'h8);
        chk("R7 rewrite no pulse", 64'(irq_out), 64'h0);
        wr(ra(0, 5), 32'h0);
        rdchk("R8 write 0 no effect", ra(0, 5), 32'h8);
        wr(ra(0, 5), 32'h8);
        rdchk("R8 pending clear", ra(0, 5), 32'h0);
        rdchk("R8 sw clear", ra(0, 4), 32'h0);

        // R3 software trigger / pending keep configurable bits (bank 0 and 1)
        wr(ra(0, 4), 32'hFFFF_FFFF);
        chk("R3 sw bank0 pulse", 64'(irq_out), 64'(cfgw(0)));
        rdchk("R3 sw bank0 stored", ra(0, 4), cfgw(0));
        rdchk("R3 pending bank0", ra(0, 5), cfgw(0));
        wr(ra(0, 5), 32'hFFFF_FFFF);
        rdchk("R8 pending bank0 clear", ra(0, 5), 32'h0);
        rdchk("R8 sw bank0 clear", ra(0, 4), 32'h0);
        wr(ra(1, 4), 32'hFFFF_FFFF);
        chk("R3 sw bank1 pulse", 64'(irq_out), 64'(cfgw(1)) << 32);
        rdchk("R3 sw bank1 stored", ra(1, 4), cfgw(1));
        rdchk("R3 pending bank1", ra(1, 5), cfgw(1));
        wr(ra(1, 5), 32'hFFFF_FFFF);
        rdchk("R8 pending bank1 clear", ra(1, 5), 32'h0);

        // R7 masked software trigger stores but does not fire
        wr(ra(0, 0), 32'hFFFF_FFF7);
        wr(ra(0, 4), 32'h8);
        chk("R7 masked no pulse", 64'(irq_out), 64'h0);
        rdchk("R7 masked no pending", ra(0, 5), 32'h0);
        rdchk("R7 masked stored", ra(0, 4), 32'h8);
        wr(ra(0, 0), 32'hFFFF_FFFF);
        wr(ra(0, 4), 32'h8);
        chk("R7 no 0to1 no pulse", 64'(irq_out), 64'h0);
        wr(ra(0, 5), 32'h8);
        rdchk("R8 clear idle keeps sw", ra(0, 4), 32'h8);
        wr(ra(0, 4), 32'h0);
        wr(ra(0, 4), 32'h8);
        chk("R7 new 0to1 pulse", 64'(irq_out), 64'h8);
        wr(ra(0, 5), 32'h8);

        // R7 software trigger on an already pending line
        step(); line_in[4] = 1'b1;
        step();
        chk("R5 edge line 4", 64'(irq_out), 64'h10);
        wr(ra(0, 4), 32'h10);
        chk("R7 already pending no pulse", 64'(irq_out), 64'h0);
        rdchk("R7 sw stored while pending", ra(0, 4), 32'h10);
        wr(ra(0, 5), 32'h10);
        rdchk("R8 sw cleared with pending", ra(0, 4), 32'h0);
        line_in[4] = 1'b0;
        step();
        wr(ra(0, 5), 32'h10);

        // R9 clear write and edge in the same cycle
        @(negedge clk);
        line_in[6] = 1'b1;
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 10'h14; reg_wdata = 32'h40;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        chk("R9 pulse kept", 64'(irq_out), 64'h40);
        rdchk("R9 clear wins", ra(0, 5), 32'h0);
        line_in[6] = 1'b0;
        step();
        wr(ra(0, 5), 32'h40);

        // R10 undefined and unaligned offsets
        rdchk("R10 read imr", ra(0, 0), 32'hFFFF_FFFF);
        rdchk("R10 offset 0x18", 'h18, 32'h0);
        rdchk("R10 read imr1", ra(1, 0), 32'h0000_00FF);
        rdchk("R10 offset 0x3C", 'h3C, 32'h0);
        rdchk("R10 read imr", ra(0, 0), 32'hFFFF_FFFF);
        rdchk("R10 offset 0x40", 'h40, 32'h0);
        rdchk("R10 read imr", ra(0, 0), 32'hFFFF_FFFF);
        rdchk("R10 offset 0x3FC", 'h3FC, 32'h0);
        rdchk("R10 read imr", ra(0, 0), 32'hFFFF_FFFF);
        rdchk("R10 unaligned read", 'h02, 32'h0);
        wr('h01, 32'h0);
        rdchk("R10 unaligned write ignored", ra(0, 0), 32'hFFFF_FFFF);
        wr('h40, 32'h0);
        rdchk("R10 0x40 write ignored", ra(0, 0), 32'hFFFF_FFFF);
        wr('h60, 32'h0);
        rdchk("R10 0x60 write ignored", ra(1, 0), 32'h0000_00FF);
        wr('h18, 32'hFFFF_FFFF);
        rdchk("R10 0x18 write ignored", ra(0, 5), 32'h0);
        rdchk("R10 0x18 write ignored sw", ra(0, 4), 32'h0);
        chk("R10 no pulse", 64'(irq_out), 64'h0);
        wr('h38, 32'hFFFF_FFFF);
        rdchk("R10 0x38 write ignored", ra(1, 5), 32'h0);
        rdchk("R10 emr1 untouched", ra(1, 1), 32'h0);

        done = 1;
        summary();
        $finish;
    end

endmodule